// File: doc/BRIEF.md
# Receive Word FIFO with Exponent-Coded Trigger

This block buffers the words that a serial shift engine has received until bus software reads them. It has 32 bytes of storage. In narrow mode each entry is one byte, so it holds 32 words. In wide mode each entry takes two bytes, so it holds 16 half-words. Software reads a byte-count level and drains the data through a read window. Every read of the window pops one word, padded with zeros to the bus width. A write of zero to the level register discards everything held.

A 3-bit code picks a fill threshold of a power of two words. When the count first climbs to that threshold while triggering is enabled, a sticky trigger flag rises. An engine word that arrives with no free entry is dropped, and a sticky overflow flag records the loss. Both flags stay set until the status logic clears them with their clear strobes.

Top module: `rx_trig_fifo`

## Requirements
- R1: After a synchronous active-low reset the level is 0, the window reads 0, and both flags are low.
- R2: The level reports bytes held: the word count in narrow mode (`wide_mode`=0, up to 32 words) and twice the word count in wide mode (`wide_mode`=1, up to 16 words), so a full FIFO always reads 32.
- R3: The window shows the oldest word, zero-extended to 32 bits. In narrow mode only bits 7:0 of the stored word are shown. A read while not empty pops exactly one word. A read while empty is ignored, and an empty FIFO shows 0.
- R4: A push and a pop in the same cycle leave the level unchanged and keep arrival order. This holds even when the FIFO is full, and in that case no overflow is raised.
- R5: A level write with data 0 empties the FIFO in one cycle and overrides a push or pop in the same cycle. A level write with any nonzero data has no effect.
- R6: Trigger code n (0 to 5) selects a threshold of 2^n words. Codes 6 and 7 select 32 words.
- R7: The trigger flag sets on the edge where the word count goes from below the threshold to the threshold while `trig_en`=1. It then holds until `trig_clr`, and a set in the same cycle as a clear wins. With `trig_en`=0 it never sets.
- R8: A push while full with no pop is dropped: the level and the stored words are unchanged. The overflow flag sets and holds until `ovf_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| push_vld | input | 1 | Engine delivers a received word |
| push_word | input | 16 | Received word |
| win_rd | input | 1 | Bus read strobe of the data window (pops) |
| lvl_wr | input | 1 | Bus write strobe of the level register |
| lvl_wdata | input | 6 | Data of the level write; 0 flushes |
| trig_code | input | 3 | Threshold exponent |
| trig_en | input | 1 | Enables the trigger flag |
| trig_clr | input | 1 | Clears the trigger flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| level_bytes | output | 6 | Bytes held |
| win_data | output | 32 | Oldest word, zero-extended |
| trig_flag | output | 1 | Sticky threshold-reached flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench fills the FIFO to exactly 32 words and then pushes once more. A design that overwrote the head or moved its pointers would show a wrong oldest word or a changed level. The bench also pushes and pops together while full. A design that compared against the full count without looking at the pop would raise a false overflow or lose the word. Threshold crossings are checked at the word before and the word at the threshold, with a clear in the same cycle, with the clamped codes, and in wide mode where 32 words cannot be reached. An off-by-one comparison or a clear-priority mistake would show up there. Flush against a concurrent push, nonzero level writes, and masking of the upper byte in narrow mode are driven so that each is visible on the level or the window.

// File: rtl/rxf_pkg.sv
// Shared definitions for the receive FIFO.
// Assumes trigger codes are small unsigned integers.
package rxf_pkg;

    typedef enum logic {
        MODE_NARROW = 1'b0,
        MODE_WIDE   = 1'b1
    } word_mode_e;

    // Threshold in words for an exponent code, clamped to 2**max_exp.
    function automatic int unsigned trig_words(input int unsigned code,
                                               input int unsigned max_exp);
        if (code > max_exp) begin
            return 32'd1 << max_exp;
        end
        return 32'd1 << code;
    endfunction

endpackage

// File: rtl/rxf_store.sv
// Circular word store with occupancy count.
// Holds DEPTH entries in narrow mode and DEPTH/2 in wide mode. DEPTH
// must be a power of two. Flush dominates push and pop. A push while
// full is accepted only when a pop happens in the same cycle;
// otherwise it is reported on ovf_evt and dropped.
module rxf_store #(
    parameter int DEPTH  = 32,
    parameter int WORD_W = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    input  logic              pop_req,
    input  logic              flush,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  cnt_d,
    output logic [WORD_W-1:0] head,
    output logic              empty,
    output logic              ovf_evt
);
    localparam logic [CNT_W-1:0] CAP_N = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CAP_W = CNT_W'(DEPTH / 2);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              full, pop_ok, push_ok;

    // Full limit depends on word size.
    always_comb begin
        full    = (cnt_q == (wide ? CAP_W : CAP_N));
        empty   = (cnt_q == '0);
        pop_ok  = pop_req && !empty && !flush;
        push_ok = push && (!full || pop_ok) && !flush;
        ovf_evt = push && full && !pop_ok && !flush;
        head    = mem[rd_ptr];
    end

    // Next occupancy count.
    always_comb begin
        cnt_d = cnt_q;
        if (flush) begin
            cnt_d = '0;
        end else if (push_ok && !pop_ok) begin
            cnt_d = cnt_q + 1'b1;
        end else if (pop_ok && !push_ok) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    // Entry write; storage carries no reset.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointer and count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (push_ok) wr_ptr <= wr_ptr + 1'b1;
                if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rxf_trig.sv
// Sticky fill-threshold flag.
// Sets when the count steps from below the threshold to at or above
// it while enabled. A set beats a clear in the same cycle. Assumes the
// count changes by at most one per cycle, except on a flush to zero.
module rxf_trig #(
    parameter int CNT_W   = 6,
    parameter int CODE_W  = 3,
    parameter int MAX_EXP = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic              en,
    input  logic              clr,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic [CNT_W-1:0]  cnt_d,
    output logic              flag
);
    logic [CNT_W-1:0] thr;
    logic             set;

    // Decode exponent into a word threshold and detect the crossing.
    always_comb begin
        thr = CNT_W'(rxf_pkg::trig_words(int'(code), MAX_EXP));
        set = en && (cnt_q < thr) && (cnt_d >= thr);
    end

    // Hold the flag until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/rx_trig_fifo.sv
// Receive FIFO top: byte-count level, pop-on-read window, exponent-coded
// trigger and sticky overflow. Assumes wide_mode changes only while
// the FIFO is empty.
module rx_trig_fifo #(
    parameter int CAP_BYTES = 32,
    parameter int WORD_W    = 16,
    parameter int CODE_W    = 3,
    parameter int BUS_W     = 32,
    localparam int LVL_W    = $clog2(CAP_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic              push_vld,
    input  logic [WORD_W-1:0] push_word,
    input  logic              win_rd,
    input  logic              lvl_wr,
    input  logic [LVL_W-1:0]  lvl_wdata,
    input  logic [CODE_W-1:0] trig_code,
    input  logic              trig_en,
    input  logic              trig_clr,
    input  logic              ovf_clr,
    output logic [LVL_W-1:0]  level_bytes,
    output logic [BUS_W-1:0]  win_data,
    output logic              trig_flag,
    output logic              ovf_flag
);
    import rxf_pkg::*;

    localparam int DEPTH   = CAP_BYTES;
    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int MAX_EXP = $clog2(DEPTH);
    localparam int NARR_W  = 8;

    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [WORD_W-1:0] head;
    logic              empty, ovf_evt, flush;
    word_mode_e        mode;

    // Decode bus strobes and mode.
    always_comb begin
        mode  = word_mode_e'(wide_mode);
        flush = lvl_wr && (lvl_wdata == '0);
    end

    rxf_store #(
        .DEPTH (DEPTH),
        .WORD_W(WORD_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wide     (mode == MODE_WIDE),
        .push     (push_vld),
        .push_data(push_word),
        .pop_req  (win_rd),
        .flush    (flush),
        .cnt_q    (cnt_q),
        .cnt_d    (cnt_d),
        .head     (head),
        .empty    (empty),
        .ovf_evt  (ovf_evt)
    );

    rxf_trig #(
        .CNT_W  (CNT_W),
        .CODE_W (CODE_W),
        .MAX_EXP(MAX_EXP)
    ) u_trig (
        .clk  (clk),
        .rst_n(rst_n),
        .code (trig_code),
        .en   (trig_en),
        .clr  (trig_clr),
        .cnt_q(cnt_q),
        .cnt_d(cnt_d),
        .flag (trig_flag)
    );

    // Byte level and zero-extended window view.
    always_comb begin
        if (mode == MODE_WIDE) begin
            level_bytes = LVL_W'({cnt_q, 1'b0});
            win_data    = empty ? '0 : BUS_W'(head);
        end else begin
            level_bytes = LVL_W'(cnt_q);
            win_data    = empty ? '0 : BUS_W'(head[NARR_W-1:0]);
        end
    end

    // Sticky overflow; a new event beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
        end else if (ovf_evt) begin
            ovf_flag <= 1'b1;
        end else if (ovf_clr) begin
            ovf_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/rxf_checker.sv
// Port-level properties of rx_trig_fifo, bound onto every instance.
module rxf_checker #(
    parameter int CAP_BYTES = 32,
    parameter int WORD_W    = 16,
    parameter int CODE_W    = 3,
    parameter int BUS_W     = 32,
    localparam int LVL_W    = $clog2(CAP_BYTES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wide_mode,
    input logic              push_vld,
    input logic [WORD_W-1:0] push_word,
    input logic              win_rd,
    input logic              lvl_wr,
    input logic [LVL_W-1:0]  lvl_wdata,
    input logic [CODE_W-1:0] trig_code,
    input logic              trig_en,
    input logic              trig_clr,
    input logic              ovf_clr,
    input logic [LVL_W-1:0]  level_bytes,
    input logic [BUS_W-1:0]  win_data,
    input logic              trig_flag,
    input logic              ovf_flag
);
    logic flushing, full;
    always_comb begin
        flushing = lvl_wr && (lvl_wdata == '0);
        full     = (level_bytes == LVL_W'(CAP_BYTES));
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (level_bytes == '0 && !trig_flag && !ovf_flag && win_data == '0));

    assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (level_bytes <= LVL_W'(CAP_BYTES)) && (!wide_mode || !level_bytes[0]));

    assert_pushpop_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_vld && win_rd && level_bytes != '0 && !flushing) |=>
        (level_bytes == $past(level_bytes) || wide_mode != $past(wide_mode)));

    assert_pushpop_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_vld && win_rd && full && !ovf_flag && !flushing) |=> !ovf_flag);

    assert_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flushing |=> (level_bytes == '0));

    assert_trig_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_en && !trig_flag) |=> !trig_flag);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_vld && !win_rd && full && !flushing) |=> ovf_flag);

    assert_ovf_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

endmodule

bind rx_trig_fifo rxf_checker #(
    .CAP_BYTES(CAP_BYTES),
    .WORD_W   (WORD_W),
    .CODE_W   (CODE_W),
    .BUS_W    (BUS_W)
) u_rxf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wide_mode  (wide_mode),
    .push_vld   (push_vld),
    .push_word  (push_word),
    .win_rd     (win_rd),
    .lvl_wr     (lvl_wr),
    .lvl_wdata  (lvl_wdata),
    .trig_code  (trig_code),
    .trig_en    (trig_en),
    .trig_clr   (trig_clr),
    .ovf_clr    (ovf_clr),
    .level_bytes(level_bytes),
    .win_data   (win_data),
    .trig_flag  (trig_flag),
    .ovf_flag   (ovf_flag)
);

// File: tb/tb_rx_trig_fifo.sv
`timescale 1ns/1ps
module tb_rx_trig_fifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b0, push_vld = 1'b0, win_rd = 1'b0, lvl_wr = 1'b0;
    logic [15:0] push_word = '0;
    logic [5:0]  lvl_wdata = '0;
    logic [2:0]  trig_code = '0;
    logic        trig_en = 1'b0, trig_clr = 1'b0, ovf_clr = 1'b0;
    logic [5:0]  level_bytes;
    logic [31:0] win_data;
    logic        trig_flag, ovf_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rx_trig_fifo dut (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .push_vld(push_vld),
        .push_word(push_word), .win_rd(win_rd), .lvl_wr(lvl_wr),
        .lvl_wdata(lvl_wdata), .trig_code(trig_code), .trig_en(trig_en),
        .trig_clr(trig_clr), .ovf_clr(ovf_clr), .level_bytes(level_bytes),
        .win_data(win_data), .trig_flag(trig_flag), .ovf_flag(ovf_flag)
    );

    typedef struct packed {
        logic        w;
        logic        push;
        logic [15:0] pd;
        logic        rd;
        logic        lw;
        logic [5:0]  lwd;
        logic [2:0]  code;
        logic        en;
        logic        tclr;
        logic [5:0]  e_lvl;
        logic [15:0] e_dat;
        logic        e_trig;
        logic        e_ovf;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b1,16'h00A5,1'b0,1'b0,6'd0,3'd1,1'b1,1'b0, 6'd1,16'h00A5,1'b0,1'b0},
        '{1'b0,1'b1,16'h003C,1'b0,1'b0,6'd0,3'd1,1'b1,1'b0, 6'd2,16'h00A5,1'b1,1'b0},
        '{1'b0,1'b0,16'h0000,1'b0,1'b0,6'd0,3'd1,1'b1,1'b1, 6'd2,16'h00A5,1'b0,1'b0},
        '{1'b0,1'b0,16'h0000,1'b1,1'b0,6'd0,3'd1,1'b1,1'b0, 6'd1,16'h003C,1'b0,1'b0},
        '{1'b0,1'b1,16'h007F,1'b1,1'b0,6'd0,3'd1,1'b1,1'b0, 6'd1,16'h007F,1'b0,1'b0},
        '{1'b0,1'b0,16'h0000,1'b1,1'b0,6'd0,3'd1,1'b1,1'b0, 6'd0,16'h0000,1'b0,1'b0},
        '{1'b0,1'b0,16'h0000,1'b1,1'b0,6'd0,3'd1,1'b1,1'b0, 6'd0,16'h0000,1'b0,1'b0},
        '{1'b1,1'b1,16'h1234,1'b0,1'b0,6'd0,3'd0,1'b1,1'b0, 6'd2,16'h1234,1'b1,1'b0},
        '{1'b1,1'b1,16'hABCD,1'b0,1'b0,6'd0,3'd0,1'b1,1'b1, 6'd4,16'h1234,1'b0,1'b0},
        '{1'b1,1'b1,16'h5555,1'b0,1'b1,6'd0,3'd0,1'b1,1'b0, 6'd0,16'h0000,1'b0,1'b0},
        '{1'b0,1'b1,16'h01FF,1'b0,1'b0,6'd0,3'd0,1'b0,1'b0, 6'd1,16'h00FF,1'b0,1'b0},
        '{1'b0,1'b0,16'h0000,1'b0,1'b1,6'd5,3'd0,1'b0,1'b0, 6'd1,16'h00FF,1'b0,1'b0}
    };
    localparam string TAGS [NV] = '{"R3","R7","R7","R3","R4","R3","R3",
                                     "R6","R7","R5","R3","R5"};

    // Apply one cycle of strobes at a falling edge; return at the next falling edge.
    task automatic cyc(input logic p, input logic [15:0] d, input logic r,
                       input logic lw, input logic [5:0] lwd,
                       input logic tc, input logic oc);
        push_vld = p; push_word = d; win_rd = r; lvl_wr = lw; lvl_wdata = lwd;
        trig_clr = tc; ovf_clr = oc;
        @(negedge clk);
        push_vld = 1'b0; win_rd = 1'b0; lvl_wr = 1'b0; trig_clr = 1'b0; ovf_clr = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [5:0] el, input logic [31:0] ed,
                       input logic et, input logic eo);
        n_chk++;
        if (level_bytes !== el || win_data !== ed || trig_flag !== et || ovf_flag !== eo) begin
            n_bad++;
            $display("FAIL %s: got lvl=%0d data=%h trig=%b ovf=%b, exp lvl=%0d data=%h trig=%b ovf=%b",
                     tag, level_bytes, win_data, trig_flag, ovf_flag, el, ed, et, eo);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", 6'd0, 32'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            wide_mode = TBL[i].w; trig_code = TBL[i].code; trig_en = TBL[i].en;
            cyc(TBL[i].push, TBL[i].pd, TBL[i].rd, TBL[i].lw, TBL[i].lwd, TBL[i].tclr, 1'b0);
            chk(TAGS[i], TBL[i].e_lvl, {16'h0, TBL[i].e_dat}, TBL[i].e_trig, TBL[i].e_ovf);
        end

        // Narrow fill to 32 with code 5, then overflow (R2, R6, R7, R8)
        wide_mode = 1'b0; trig_code = 3'd5; trig_en = 1'b1;
        cyc(1'b0, 16'h0, 1'b0, 1'b1, 6'd0, 1'b1, 1'b0);
        for (int i = 1; i <= 31; i++) cyc(1'b1, 16'(i), 1'b0, 1'b0, 6'd0, 1'b0, 1'b0);
        chk("R7", 6'd31, 32'h1, 1'b0, 1'b0);
        cyc(1'b1, 16'd32, 1'b0, 1'b0, 6'd0, 1'b0, 1'b0);
        chk("R2", 6'd32, 32'h1, 1'b1, 1'b0);
        cyc(1'b1, 16'h00EE, 1'b0, 1'b0, 6'd0, 1'b0, 1'b0);
        chk("R8", 6'd32, 32'h1, 1'b1, 1'b1);
        cyc(1'b1, 16'h0077, 1'b1, 1'b0, 6'd0, 1'b0, 1'b0);
        chk("R4", 6'd32, 32'h2, 1'b1, 1'b1);
        cyc(1'b0, 16'h0, 1'b0, 1'b0, 6'd0, 1'b0, 1'b1);
        chk("R8", 6'd32, 32'h2, 1'b1, 1'b0);

        // Drain and verify order (R3)
        begin
            int bad_order = 0;
            for (int i = 2; i <= 33; i++) begin
                logic [31:0] ex;
                ex = (i == 33) ? 32'h77 : 32'(i);
                if (win_data !== ex) bad_order++;
                cyc(1'b0, 16'h0, 1'b1, 1'b0, 6'd0, 1'b0, 1'b0);
            end
            n_chk++;
            if (bad_order != 0) begin
                n_bad++;
                $display("FAIL R3: drain order got %0d wrong words, expected 0", bad_order);
            end
        end
        chk("R3", 6'd0, 32'h0, 1'b1, 1'b0);

        // Threshold 4 words, set beats clear (R6, R7)
        trig_code = 3'd2;
        cyc(1'b0, 16'h0, 1'b0, 1'b0, 6'd0, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) cyc(1'b1, 16'h40 + 16'(i), 1'b0, 1'b0, 6'd0, 1'b0, 1'b0);
        chk("R6", 6'd3, 32'h40, 1'b0, 1'b0);
        cyc(1'b1, 16'h43, 1'b0, 1'b0, 6'd0, 1'b1, 1'b0);
        chk("R7", 6'd4, 32'h40, 1'b1, 1'b0);

        // Wide fill with clamped code 6: 32 words unreachable (R2, R6, R8)
        wide_mode = 1'b1; trig_code = 3'd6;
        cyc(1'b0, 16'h0, 1'b0, 1'b1, 6'd0, 1'b1, 1'b0);
        for (int i = 0; i < 16; i++) cyc(1'b1, 16'h1000 + 16'(i), 1'b0, 1'b0, 6'd0, 1'b0, 1'b0);
        chk("R6", 6'd32, 32'h1000, 1'b0, 1'b0);
        cyc(1'b1, 16'hBEEF, 1'b0, 1'b0, 6'd0, 1'b0, 1'b0);
        chk("R8", 6'd32, 32'h1000, 1'b0, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule